// File: doc/BRIEF.md
# Serial ADC Frame Host Controller

This block runs a small successive-approximation converter that has a three-wire serial port. The controller works from a fast system clock. It makes the active-low chip-select and a serial clock divided down from the system clock, and it shifts in the converter's reply. Each 8-bit sample goes out on a valid/ready port. A one-cycle request pulse asks for a sample. A level input selects low-power operation.

The converter needs several timing rules, and the controller keeps all of them.

- **Frame shape:** every full conversion frame is exactly sixteen serial clock periods long.
- **Track gap:** after the thirteenth rising clock edge the converter tracks its input. The next chip-select fall is held off for a minimum track interval. That interval is counted in system cycles and rounded up to whole serial periods.
- **Dummy frame:** the first conversion after reset, or after a wake from shutdown, is run but its result is thrown away.
- **Low-power parking:** with low-power selected, the controller returns the converter to shutdown between requests. It does this by raising chip-select inside the edge window where the converter treats an aborted frame as a shutdown command.

Top module: `adc_frame_host`

## Requirements
- R1: While reset is held, chip-select is high, the serial clock is high and the sample valid output is low.
- R2: In a frame, chip-select falls while the serial clock is high, and the clock stays high for at least one system cycle after that. Each clock phase then lasts exactly HALF_DIV system cycles, with the first falling edge HALF_DIV cycles after chip-select falls. A full frame keeps chip-select low for exactly FRAME_BITS (16) serial periods.
- R3: The line is sampled on each rising serial edge. Bit n is the value captured on rising edge n. Bits 1 to 3 are leading zeros, and bits 4 to 11 form the sample, most significant bit first. The sample appears on smp_data_o.
- R4: smp_err_o goes high together with a delivered sample when any of the three leading bits was 1. The sample is delivered all the same.
- R5: A gap of GAP_LEN system cycles is kept before the next chip-select fall. GAP_LEN = max(ceil(ACQ_CYC / (2*HALF_DIV)), 4) * 2*HALF_DIV. After a full frame the gap is counted from the 13th rising edge. After an aborted frame it is counted from the chip-select rise.
- R6: The first full frame after reset, and the first after a parking frame, is a dummy. Its result is not delivered, and it is followed by a second full frame whose result is delivered.
- R7: While lowpwr_i is 1, the controller runs a parking frame whenever it is idle, the converter is awake and no request is pending. This happens after every delivered sample, and also when lowpwr_i rises while the converter is awake. In a parking frame, chip-select rises after exactly SHUT_EDGE falling edges (2 to 9), at SHUT_EDGE serial periods.
- R8: While lowpwr_i is 0 and the converter is awake, each request produces exactly one full frame and no parking frame.
- R9: A delivered sample holds valid and its data stable until smp_ready_i is seen high. No frame that would deliver a sample starts while the output still holds an unaccepted sample.
- R10: A request that arrives during a frame or a gap is held pending. When the gap ends it is served with chip-select falling exactly GAP_LEN cycles after the previous 13th rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | One-cycle sample request |
| lowpwr_i | input | 1 | Park the converter in shutdown between requests |
| smp_ready_i | input | 1 | Consumer accepts the held sample |
| adc_sdata_i | input | 1 | Serial data from the converter |
| adc_cs_n_o | output | 1 | Active-low chip-select to the converter |
| adc_sclk_o | output | 1 | Serial clock to the converter, idle high |
| smp_valid_o | output | 1 | A sample is held on smp_data_o |
| smp_data_o | output | DATA_W | Delivered sample |
| smp_err_o | output | 1 | Leading-zero check failed for the held sample |

## Verification
The bound checker watches the serial pins on every cycle. It checks that:
- the clock is parked high whenever chip-select is high;
- there is setup before the first falling edge;
- each chip-select low time is either a full frame or a parking abort;
- each chip-select high time meets the track gap for the kind of frame that came before it;
- a held sample stays stable under backpressure.

Which frames are dummies, which are parking aborts, and whether a delivered byte matches the serial word can only be shown by the bench's scenarios. The same holds for the error flag on a corrupted leading bit and for a request queued during a running frame. These scenarios pair a converter model with the predicted frame sequence.

// File: rtl/adcc_pkg.sv
package adcc_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_RUN
  } adcc_state_e;

  typedef enum logic [1:0] {
    FK_DUMMY,
    FK_REAL,
    FK_PARK
  } adcc_kind_e;

  // Track gap in system cycles: whole serial periods, at least min_per of them.
  function automatic int adcc_gap_len(input int half, input int acq, input int min_per);
    int per;
    int n;
    per = 2 * half;
    n = (acq + per - 1) / per;
    if (n < min_per) n = min_per;
    return n * per;
  endfunction

endpackage

// File: rtl/adcc_sclk_gen.sv
module adcc_sclk_gen #(
  parameter int HALF_DIV = 7,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  output logic             sclk_o,
  output logic             rise_tick_o,
  output logic [CNT_W-1:0] rise_cnt_o
);
  localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [HW-1:0] H_LAST = HW'(HALF_DIV - 1);

  logic [HW-1:0]    hcnt_q;
  logic             sclk_q;
  logic [CNT_W-1:0] rcnt_q;
  logic             phase_end;

  assign phase_end = (hcnt_q == H_LAST);

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      hcnt_q <= '0;
      sclk_q <= 1'b1;
      rcnt_q <= '0;
    end else if (phase_end) begin
      hcnt_q <= '0;
      sclk_q <= ~sclk_q;
      if (!sclk_q) rcnt_q <= rcnt_q + CNT_W'(1);
    end else begin
      hcnt_q <= hcnt_q + HW'(1);
    end
  end

  assign sclk_o      = sclk_q;
  assign rise_tick_o = run_i && phase_end && !sclk_q;
  assign rise_cnt_o  = rcnt_q;
endmodule

// File: rtl/adcc_gap_timer.sv
module adcc_gap_timer #(
  parameter int LEN = 56
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic done_o
);
  localparam int GW = $clog2(LEN + 1);

  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (start_i)       cnt_q <= GW'(LEN - 1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - GW'(1);
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/adcc_capture.sv
module adcc_capture #(
  parameter int LEAD_BITS = 3,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_i,
  input  logic              din_i,
  output logic [DATA_W-1:0] data_o,
  output logic              lead_bad_o
);
  localparam int CAP_W = LEAD_BITS + DATA_W;

  logic [CAP_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst)          word_q <= '0;
    else if (shift_i) word_q <= {word_q[CAP_W-2:0], din_i};
  end

  assign data_o     = word_q[DATA_W-1:0];
  assign lead_bad_o = |word_q[CAP_W-1 -: LEAD_BITS];
endmodule

// File: rtl/adc_frame_host.sv
module adc_frame_host
  import adcc_pkg::*;
#(
  parameter int HALF_DIV   = 7,
  parameter int ACQ_CYC    = 18,
  parameter int SHUT_EDGE  = 4,
  parameter int DATA_W     = 8,
  parameter int LEAD_BITS  = 3,
  parameter int FRAME_BITS = 16,
  parameter int TRACK_EDGE = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              lowpwr_i,
  input  logic              smp_ready_i,
  input  logic              adc_sdata_i,
  output logic              adc_cs_n_o,
  output logic              adc_sclk_o,
  output logic              smp_valid_o,
  output logic [DATA_W-1:0] smp_data_o,
  output logic              smp_err_o
);
  localparam int CW      = $clog2(FRAME_BITS + 1);
  localparam int CAP_W   = LEAD_BITS + DATA_W;
  localparam int MIN_PER = FRAME_BITS - TRACK_EDGE + 1;
  localparam int GAP_LEN = adcc_gap_len(HALF_DIV, ACQ_CYC, MIN_PER);

  adcc_state_e       st_q;
  adcc_kind_e        kind_q;
  logic              run_q, cs_n_q, pend_q, primed_q, valid_q, err_q;
  logic [DATA_W-1:0] data_q;

  logic              rise_tick;
  logic [CW-1:0]     rise_cnt, rise_n;
  logic              gap_done, gap_start, shift_en;
  logic              park_stop, track_hit, frame_end;
  logic [DATA_W-1:0] cap_data;
  logic              cap_bad;

  adcc_sclk_gen #(.HALF_DIV(HALF_DIV), .CNT_W(CW)) u_sclk (
    .clk(clk), .rst(rst), .run_i(run_q),
    .sclk_o(adc_sclk_o), .rise_tick_o(rise_tick), .rise_cnt_o(rise_cnt)
  );

  adcc_gap_timer #(.LEN(GAP_LEN)) u_gap (
    .clk(clk), .rst(rst), .start_i(gap_start), .done_o(gap_done)
  );

  adcc_capture #(.LEAD_BITS(LEAD_BITS), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .shift_i(shift_en), .din_i(adc_sdata_i),
    .data_o(cap_data), .lead_bad_o(cap_bad)
  );

  always_comb begin
    rise_n    = rise_cnt + CW'(1);
    park_stop = rise_tick && (kind_q == FK_PARK) && (rise_n == CW'(SHUT_EDGE));
    track_hit = rise_tick && (kind_q != FK_PARK) && (rise_n == CW'(TRACK_EDGE));
    frame_end = rise_tick && (kind_q != FK_PARK) && (rise_n == CW'(FRAME_BITS));
    gap_start = park_stop || track_hit;
    shift_en  = rise_tick && (rise_n <= CW'(CAP_W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      kind_q   <= FK_DUMMY;
      run_q    <= 1'b0;
      cs_n_q   <= 1'b1;
      pend_q   <= 1'b0;
      primed_q <= 1'b0;
      valid_q  <= 1'b0;
      err_q    <= 1'b0;
      data_q   <= '0;
    end else begin
      if (valid_q && smp_ready_i) valid_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (gap_done) begin
            if (pend_q && (!primed_q || !valid_q)) begin
              st_q   <= ST_RUN;
              run_q  <= 1'b1;
              cs_n_q <= 1'b0;
              kind_q <= primed_q ? FK_REAL : FK_DUMMY;
              if (primed_q) pend_q <= 1'b0;
            end else if (primed_q && lowpwr_i && !pend_q) begin
              st_q   <= ST_RUN;
              run_q  <= 1'b1;
              cs_n_q <= 1'b0;
              kind_q <= FK_PARK;
            end
          end
        end
        ST_RUN: begin
          if (park_stop) begin
            st_q     <= ST_IDLE;
            run_q    <= 1'b0;
            cs_n_q   <= 1'b1;
            primed_q <= 1'b0;
          end else if (frame_end) begin
            st_q   <= ST_IDLE;
            run_q  <= 1'b0;
            cs_n_q <= 1'b1;
            if (kind_q == FK_DUMMY) begin
              primed_q <= 1'b1;
            end else begin
              valid_q <= 1'b1;
              data_q  <= cap_data;
              err_q   <= cap_bad;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
      if (req_i) pend_q <= 1'b1;
    end
  end

  assign adc_cs_n_o  = cs_n_q;
  assign smp_valid_o = valid_q;
  assign smp_data_o  = data_q;
  assign smp_err_o   = err_q;
endmodule

// File: rtl/adcc_chk.sv
module adcc_chk #(
  parameter int HALF_DIV   = 7,
  parameter int GAP_LEN    = 56,
  parameter int SHUT_EDGE  = 4,
  parameter int FRAME_BITS = 16,
  parameter int TRACK_EDGE = 13,
  parameter int DATA_W     = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              sclk,
  input logic              valid,
  input logic              ready,
  input logic [DATA_W-1:0] data
);
  localparam int PER = 2 * HALF_DIV;
  localparam logic [15:0] L_FULL = 16'(FRAME_BITS * PER);
  localparam logic [15:0] L_PARK = 16'(SHUT_EDGE * PER);
  localparam logic [15:0] G_FULL = 16'(GAP_LEN - (FRAME_BITS - TRACK_EDGE) * PER);
  localparam logic [15:0] G_PARK = 16'(GAP_LEN);

  logic [15:0] hi_cnt, lo_cnt, lo_len;
  logic        seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
      lo_len <= '0;
      seen   <= 1'b0;
    end else if (cs_n) begin
      if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
      if (lo_cnt != '0) begin
        lo_len <= lo_cnt;
        seen   <= 1'b1;
      end
      lo_cnt <= '0;
    end else begin
      hi_cnt <= '0;
      if (lo_cnt != 16'hFFFF) lo_cnt <= lo_cnt + 16'd1;
    end
  end

  // R2
  sclk_parked_chk: assert property (@(posedge clk) disable iff (rst) cs_n |-> sclk);

  // R2
  cs_setup_chk: assert property (@(posedge clk) disable iff (rst) $fell(cs_n) |-> sclk);

  // R7
  cs_low_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (lo_cnt == L_FULL || lo_cnt == L_PARK));

  // R5
  track_gap_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(cs_n) && seen) |-> (hi_cnt >= ((lo_len == L_FULL) ? G_FULL : G_PARK)));

  // R9
  hold_sample_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(data)));
endmodule

bind adc_frame_host adcc_chk #(
  .HALF_DIV(HALF_DIV), .GAP_LEN(GAP_LEN), .SHUT_EDGE(SHUT_EDGE),
  .FRAME_BITS(FRAME_BITS), .TRACK_EDGE(TRACK_EDGE), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .cs_n(adc_cs_n_o), .sclk(adc_sclk_o),
  .valid(smp_valid_o), .ready(smp_ready_i), .data(smp_data_o)
);

// File: tb/sim_adc_frame_host.sv
module sim_adc_frame_host;
  localparam int HALF = 7;
  localparam int ACQ = 18;
  localparam int SHUT = 4;
  localparam int FRAME = 16;
  localparam int PER = 2 * HALF;
  localparam int GAPP = ((ACQ + PER - 1) / PER < 4) ? 4 : (ACQ + PER - 1) / PER;
  localparam int GAP_LEN = GAPP * PER;

  logic clk = 0, rst = 1, req = 0, lowpwr = 0, ready = 1, sdata = 0;
  logic cs_n, sclk, valid, err;
  logic [7:0] data;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] q_code[$];
  bit         q_err[$];
  int         q_frm[$];
  int fi_pred = 0;
  bit asleep = 1;
  int corrupt_fi = -1;

  // converter model state
  int fi = -1, falls = 0, rises = 0, t_fall = 0, t_rise = 0, t13 = 0, t_edge = 0;
  int last_gap = -1, len = 0, expf = 0;
  bit last_full = 0, phase_ok = 1, prev_cs = 1, prev_sclk = 1, cur_bad = 0;
  logic [7:0] cur_code;

  adc_frame_host #(.HALF_DIV(HALF), .ACQ_CYC(ACQ), .SHUT_EDGE(SHUT)) u0 (
    .clk(clk), .rst(rst), .req_i(req), .lowpwr_i(lowpwr), .smp_ready_i(ready),
    .adc_sdata_i(sdata), .adc_cs_n_o(cs_n), .adc_sclk_o(sclk),
    .smp_valid_o(valid), .smp_data_o(data), .smp_err_o(err)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] code_of(input int k);
    if (k == 3) return 8'hFF;
    if (k == 4) return 8'h00;
    return 8'((k * 73 + 29) & 255);
  endfunction

  function automatic logic bit_of(input int n);
    if (n >= 1 && n <= 3) return cur_bad && (n == 2);
    if (n >= 4 && n <= 11) return cur_code[11-n];
    return 1'b0;
  endfunction

  // converter model and frame monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_cs && !cs_n) begin
        fi++;
        cur_code = code_of(fi);
        cur_bad  = (fi == corrupt_fi);
        if (fi > 0) begin
          last_gap = last_full ? cyc - t13 : cyc - t_rise;
          chk(last_gap >= GAP_LEN, "R5", last_gap, GAP_LEN);
        end
        falls = 0; rises = 0; t_fall = cyc; t_edge = cyc; phase_ok = 1;
        sdata = bit_of(1);
      end else if (!prev_cs && cs_n) begin
        len = cyc - t_fall;
        t_rise = cyc;
        last_full = (falls == FRAME);
        if (q_frm.size() == 0) chk(0, "R7", falls, -1);
        else begin
          expf = q_frm.pop_front();
          chk(falls == expf, (expf == FRAME) ? "R6" : "R7", falls, expf);
        end
        chk(phase_ok && len == falls * PER, "R2", len, falls * PER);
      end else if (!cs_n) begin
        if (prev_sclk != sclk) begin
          if (cyc - t_edge != HALF) phase_ok = 0;
          t_edge = cyc;
        end
        if (prev_sclk && !sclk) begin
          falls++;
          sdata = bit_of(falls);
        end
        if (!prev_sclk && sclk) begin
          rises++;
          if (rises == 13) t13 = cyc;
        end
      end
      prev_cs = cs_n;
      prev_sclk = sclk;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && valid && ready) begin
      if (q_code.size() == 0) chk(0, "R6", data, -1);
      else begin
        logic [7:0] ec;
        bit ee;
        ec = q_code.pop_front();
        ee = q_err.pop_front();
        chk(data == ec, "R3", data, ec);
        chk(err == ee, "R4", err, ee);
      end
    end
  end

  task automatic do_request(input bit bad);
    if (asleep) begin
      q_frm.push_back(FRAME);
      fi_pred++;
    end
    if (bad) corrupt_fi = fi_pred;
    q_code.push_back(code_of(fi_pred));
    q_err.push_back(bad);
    q_frm.push_back(FRAME);
    fi_pred++;
    if (lowpwr) begin
      q_frm.push_back(SHUT);
      fi_pred++;
      asleep = 1;
    end else asleep = 0;
    req = 1;
    @(negedge clk);
    req = 0;
  endtask

  task automatic set_low(input bit v);
    lowpwr = v;
    if (v && !asleep) begin
      q_frm.push_back(SHUT);
      fi_pred++;
      asleep = 1;
    end
  endtask

  task automatic drain();
    while (q_frm.size() != 0 || q_code.size() != 0) @(negedge clk);
    repeat (GAP_LEN + 2 * PER) @(negedge clk);
  endtask

  initial begin
    int f0;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R1", cs_n, 1);
    chk(sclk == 1'b1, "R1", sclk, 1);
    chk(valid == 1'b0, "R1", valid, 0);
    rst = 0;
    repeat (2) @(negedge clk);

    // R6: first request after reset runs a dummy then a delivered frame
    do_request(0);
    drain();
    chk(fi == 1, "R6", fi, 1);

    // R8: awake, normal power: one frame per request
    f0 = fi;
    do_request(0);
    drain();
    chk(fi - f0 == 1, "R8", fi - f0, 1);
    do_request(0);                 // all-ones sample, R3
    drain();

    // R4: corrupted leading bit, all-zero sample still delivered
    do_request(1);
    drain();

    // R10: second request during a running frame
    do_request(0);
    while (cs_n) @(negedge clk);
    repeat (3) @(negedge clk);
    do_request(0);
    drain();
    chk(last_gap == GAP_LEN, "R10", last_gap, GAP_LEN);

    // R9: backpressure holds the sample and blocks the next frame
    ready = 0;
    do_request(0);
    while (!valid) @(negedge clk);
    @(negedge clk);
    held = data;
    f0 = fi;
    do_request(0);
    repeat (400) @(negedge clk);
    chk(valid == 1'b1 && data == held, "R9", data, held);
    chk(cs_n == 1'b1 && fi == f0, "R9", fi, f0);
    ready = 1;
    drain();

    // R7: entering low power parks the awake converter
    set_low(1);
    drain();
    chk(cs_n == 1'b1, "R7", cs_n, 1);
    do_request(0);
    drain();
    do_request(0);
    drain();

    // back to normal power: wake needs a dummy, then stays awake
    set_low(0);
    do_request(0);
    drain();
    f0 = fi;
    do_request(0);
    drain();
    chk(fi - f0 == 1, "R8", fi - f0, 1);
    chk(q_code.size() == 0, "R3", q_code.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(negedge clk) begin
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule